// File: doc/BRIEF.md
# Dual Timer/Counter with Split and Auto-Reload Modes

This block holds two 16-bit count channels, each kept as a low byte and a high byte, and one shared 8-bit control byte that sets how both channels run. A channel either advances on every clock (timer) or on each falling edge seen on its event pin (counter). A gate option lets an external level pin hold off counting. Each channel has an overflow flag that stays set until an acknowledge pulse clears it.

Four counting modes exist per channel: a 13-bit count with a 5-bit prescaler in the low byte, a full 16-bit count, an 8-bit count that reloads from the high byte, and a fourth code. For channel 1 the fourth code stops it. For channel 0 it splits the channel into two independent 8-bit counters: the low byte keeps channel 0's controls and flag, the high byte counts clocks under channel 1's run input and raises channel 1's flag. Channel 1 holds while that split is active.

Software reaches the control byte and the four count bytes through a small write/read bus with a combinational read path.

Top module: `dual_tmr`

## Requirements
- R1: After reset the control byte, all four count bytes and both flags read 0.
- R2: Bus address 0 is the control byte, 1/2 are channel 0 low/high, 3/4 are channel 1 low/high, other addresses read 0. In the control byte, bits [1:0] are channel 0 mode, bit 2 its event select, bit 3 its gate enable; bits [5:4], 6 and 7 are the same for channel 1. Written values read back unchanged.
- R3: With the gate enable bit at 0 a channel counts while its run input is 1; with it at 1 it counts only while both its run input and its gate pin are 1.
- R4: Event select 0 advances the channel on each enabled clock; event select 1 advances it once per 1-to-0 transition of its event pin, the count changing at the second rising clock edge after the pin falls.
- R5: Mode 00: low byte bits [4:0] count and carry into the high byte; low byte bits [7:5] hold; the flag sets when the count steps from high byte 0xFF with low bits 0x1F.
- R6: Mode 01: the 16-bit value {high, low} increments and the flag sets when it wraps from 0xFFFF to 0x0000.
- R7: Mode 10: the low byte counts; when it steps past 0xFF it is loaded with the high byte and the flag sets.
- R8: Channel 1 with mode 11, or while channel 0 is in mode 11, does not count and never raises its flag.
- R9: Channel 0 in mode 11: its low byte counts 8 bits under channel 0 run/gate/select and sets flag 0 on wrap; its high byte counts every clock while channel 1 run is 1, ignoring gate and event select, and sets flag 1 on wrap.
- R10: A flag sets in the cycle after its overflow; an acknowledge clears it in the cycle after; an overflow in the same cycle as an acknowledge leaves the flag set.
- R11: A bus write to a count byte replaces it and suppresses that channel's count step in that cycle (in split mode only the counter owning the written byte is held); a control byte write affects counting from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| run0 | input | 1 | Channel 0 run enable |
| run1 | input | 1 | Channel 1 run enable (also split high-byte enable) |
| gate_in0 | input | 1 | Channel 0 gate pin |
| gate_in1 | input | 1 | Channel 1 gate pin |
| evt_in0 | input | 1 | Channel 0 event pin |
| evt_in1 | input | 1 | Channel 1 event pin |
| ack0 | input | 1 | Flag 0 acknowledge pulse |
| ack1 | input | 1 | Flag 1 acknowledge pulse |
| flag0 | output | 1 | Channel 0 overflow flag |
| flag1 | output | 1 | Channel 1 overflow flag |

## Verification
The assertions assume every input is settled at the rising clock edge, in particular the gate pin, which enters the enable logic without synchronisation, and that the event pin holds each level for at least one clock so the two-sample edge detector sees it. The stimulus changes all inputs only on the falling edge and draws event and gate levels once per cycle, so both assumptions hold by construction. Acknowledges and bus writes are issued as single-cycle pulses, which is how the overflow-versus-acknowledge and write-versus-count collisions are reached.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int PRESC_W = 5;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    MD_PRESC  = 2'b00,
    MD_FULL   = 2'b01,
    MD_RELOAD = 2'b10,
    MD_SPLIT  = 2'b11
  } tmode_e;

  typedef struct packed {
    byte_t lo;
    byte_t hi;
    logic  wrap;
  } step_t;

  // One count step of a channel in the given mode. In MD_SPLIT only the
  // low byte is stepped here; the high byte is handled by the caller.
  function automatic step_t step_count(tmode_e m, byte_t lo, byte_t hi);
    step_t r;
    r.lo   = lo;
    r.hi   = hi;
    r.wrap = 1'b0;
    case (m)
      MD_PRESC: begin
        if (&lo[PRESC_W-1:0]) begin
          r.lo   = {lo[BYTE_W-1:PRESC_W], {PRESC_W{1'b0}}};
          r.hi   = hi + byte_t'(1);
          r.wrap = &hi;
        end else begin
          r.lo = lo + byte_t'(1);
        end
      end
      MD_FULL: begin
        {r.hi, r.lo} = {hi, lo} + {{(2*BYTE_W-1){1'b0}}, 1'b1};
        r.wrap       = &{hi, lo};
      end
      MD_RELOAD: begin
        if (&lo) begin
          r.lo   = hi;
          r.wrap = 1'b1;
        end else begin
          r.lo = lo + byte_t'(1);
        end
      end
      default: begin
        r.lo   = lo + byte_t'(1);
        r.wrap = &lo;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic s_now, s_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_now <= 1'b0;
      s_old <= 1'b0;
    end else begin
      s_now <= pin;
      s_old <= s_now;
    end
  end

  assign fall = s_old & ~s_now;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  tmode_e mode,
  input  logic   ct,
  input  logic   gate,
  input  logic   run,
  input  logic   gpin,
  input  logic   fall,
  input  logic   freeze,
  input  logic   aux_run,
  input  logic   wr_lo,
  input  logic   wr_hi,
  input  byte_t  wdata,
  output byte_t  lo,
  output byte_t  hi,
  output logic   wrap,
  output logic   aux_wrap
);
  byte_t lo_q, hi_q, lo_d, hi_d;
  logic  en, tick, split_now, halted, main_go, aux_go;
  step_t nxt;

  assign en   = run & (~gate | gpin);
  assign tick = en & (ct ? fall : 1'b1);

  generate
    if (SPLIT_OK) begin : g_split
      assign split_now = (mode == MD_SPLIT);
      assign halted    = freeze;
    end else begin : g_plain
      assign split_now = 1'b0;
      assign halted    = freeze | (mode == MD_SPLIT);
    end
  endgenerate

  assign nxt     = step_count(mode, lo_q, hi_q);
  assign main_go = tick & ~halted & (split_now ? ~wr_lo : ~(wr_lo | wr_hi));
  assign aux_go  = split_now & aux_run & ~wr_hi;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_lo)        lo_d = wdata;
    else if (main_go) lo_d = nxt.lo;
    if (wr_hi)          hi_d = wdata;
    else if (split_now) hi_d = aux_go ? hi_q + byte_t'(1) : hi_q;
    else if (main_go)   hi_d = nxt.hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo       = lo_q;
  assign hi       = hi_q;
  assign wrap     = main_go & nxt.wrap;
  assign aux_wrap = aux_go & (&hi_q);

  // R11
  wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wdata));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RELOAD && wrap) |=> lo_q == $past(hi_q));

  // R6
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FULL && wrap) |=> {hi_q, lo_q} == '0);

  // R3
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gpin && !split_now && !wr_lo && !wr_hi)
      |=> {hi_q, lo_q} == $past({hi_q, lo_q}));

  // R8
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_lo && !wr_hi) |=> ({hi_q, lo_q} == $past({hi_q, lo_q}) && !$past(wrap)));
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              run0,
  input  logic              run1,
  input  logic              gate_in0,
  input  logic              gate_in1,
  input  logic              evt_in0,
  input  logic              evt_in1,
  input  logic              ack0,
  input  logic              ack1,
  output logic              flag0,
  output logic              flag1
);
  localparam int NCH     = 2;
  localparam int FIELD_W = BYTE_W / NCH;

  byte_t            ctrl_q;
  logic [NCH-1:0]   run_v, gpin_v, evt_v, ack_v, fall_v;
  logic [NCH-1:0]   wr_lo_v, wr_hi_v, wrap_v, aux_v, set_v, flag_q;
  byte_t            lo_v [NCH];
  byte_t            hi_v [NCH];
  logic             split0;

  assign run_v  = {run1, run0};
  assign gpin_v = {gate_in1, gate_in0};
  assign evt_v  = {evt_in1, evt_in0};
  assign ack_v  = {ack1, ack0};
  assign split0 = (tmode_e'(ctrl_q[1:0]) == MD_SPLIT);

  always_ff @(posedge clk) begin
    if (!rst_n)                               ctrl_q <= '0;
    else if (bus_wr && bus_addr == '0)        ctrl_q <= bus_wdata;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign wr_lo_v[i] = bus_wr && (bus_addr == ADDR_W'(2*i+1));
      assign wr_hi_v[i] = bus_wr && (bus_addr == ADDR_W'(2*i+2));

      tmr_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (evt_v[i]),
        .fall (fall_v[i])
      );

      tmr_core #(.SPLIT_OK(i == 0)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (tmode_e'(ctrl_q[FIELD_W*i +: 2])),
        .ct      (ctrl_q[FIELD_W*i + 2]),
        .gate    (ctrl_q[FIELD_W*i + 3]),
        .run     (run_v[i]),
        .gpin    (gpin_v[i]),
        .fall    (fall_v[i]),
        .freeze  ((i != 0) && split0),
        .aux_run (run_v[(i+1) % NCH]),
        .wr_lo   (wr_lo_v[i]),
        .wr_hi   (wr_hi_v[i]),
        .wdata   (bus_wdata),
        .lo      (lo_v[i]),
        .hi      (hi_v[i]),
        .wrap    (wrap_v[i]),
        .aux_wrap(aux_v[i])
      );

      // the split high byte of one channel reports on the next channel's flag
      assign set_v[i] = wrap_v[i] | aux_v[(i+NCH-1) % NCH];

      always_ff @(posedge clk) begin
        if (!rst_n)         flag_q[i] <= 1'b0;
        else if (set_v[i])  flag_q[i] <= 1'b1;
        else if (ack_v[i])  flag_q[i] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = ctrl_q;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(2*i+1)) bus_rdata = lo_v[i];
      if (bus_addr == ADDR_W'(2*i+2)) bus_rdata = hi_v[i];
    end
  end

  assign flag0 = flag_q[0];
  assign flag1 = flag_q[1];

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_v[0] || aux_v[1]) |=> flag0);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0 && !wrap_v[0] && !aux_v[1]) |=> !flag0);

  // R9
  split_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_v[0] |=> flag1);

  // R2
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> ctrl_q == $past(bus_wdata));
endmodule

// File: tb/sim_dual_tmr.sv
`timescale 1ns/1ps
module sim_dual_tmr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       run_i [2];
  logic       gp_i  [2];
  logic       ev_i  [2];
  logic       ack_i [2];
  logic       flag0, flag1;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // reference state
  int m_ctrl;
  int m_lo [2];
  int m_hi [2];
  bit m_f  [2];
  bit h1   [2];
  bit h2   [2];

  always #2.5 clk = ~clk;

  dual_tmr u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .run0(run_i[0]), .run1(run_i[1]), .gate_in0(gp_i[0]), .gate_in1(gp_i[1]),
    .evt_in0(ev_i[0]), .evt_in1(ev_i[1]), .ack0(ack_i[0]), .ack1(ack_i[1]),
    .flag0(flag0), .flag1(flag1)
  );

  task automatic model_step();
    int  md [2];
    bit  inc[2];
    bit  ov [2];
    bit  wl [2];
    bit  wh [2];
    for (int i = 0; i < 2; i++) begin
      bit ct, gt, en, fe;
      md[i] = (m_ctrl >> (4*i)) & 3;
      ct    = ((m_ctrl >> (4*i+2)) & 1) != 0;
      gt    = ((m_ctrl >> (4*i+3)) & 1) != 0;
      fe    = h2[i] && !h1[i];
      en    = run_i[i] && (!gt || gp_i[i]);
      inc[i] = ct ? (en && fe) : en;
      wl[i] = bus_wr && (int'(bus_addr) == 2*i+1);
      wh[i] = bus_wr && (int'(bus_addr) == 2*i+2);
      ov[i] = 0;
    end
    for (int i = 0; i < 2; i++) begin
      if (i == 1 && (md[0] == 3 || md[1] == 3)) continue;
      if (i == 0 && md[0] == 3) begin
        if (inc[0] && !wl[0]) begin
          m_lo[0] = (m_lo[0] + 1) % 256;
          if (m_lo[0] == 0) ov[0] = 1;
        end
        if (run_i[1] && !wh[0]) begin
          m_hi[0] = (m_hi[0] + 1) % 256;
          if (m_hi[0] == 0) ov[1] = 1;
        end
      end else if (inc[i] && !wl[i] && !wh[i]) begin
        int v;
        case (md[i])
          0: begin
            v = m_hi[i] * 32 + (m_lo[i] % 32) + 1;
            if (v == 8192) begin v = 0; ov[i] = 1; end
            m_hi[i] = v / 32;
            m_lo[i] = (m_lo[i] & 224) | (v % 32);
          end
          1: begin
            v = m_hi[i] * 256 + m_lo[i] + 1;
            if (v == 65536) begin v = 0; ov[i] = 1; end
            m_hi[i] = v / 256;
            m_lo[i] = v % 256;
          end
          default: begin
            if (m_lo[i] == 255) begin m_lo[i] = m_hi[i]; ov[i] = 1; end
            else m_lo[i] = m_lo[i] + 1;
          end
        endcase
      end
    end
    if (bus_wr) begin
      case (int'(bus_addr))
        0: m_ctrl  = int'(bus_wdata);
        1: m_lo[0] = int'(bus_wdata);
        2: m_hi[0] = int'(bus_wdata);
        3: m_lo[1] = int'(bus_wdata);
        4: m_hi[1] = int'(bus_wdata);
        default: ;
      endcase
    end
    for (int i = 0; i < 2; i++) begin
      if (ov[i]) m_f[i] = 1;
      else if (ack_i[i]) m_f[i] = 0;
      h2[i] = h1[i];
      h1[i] = ev_i[i];
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return m_lo[0];
      2: return m_hi[0];
      3: return m_lo[1];
      4: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at cycle %0d", cur_req, what, got, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ctrl = 0;
      for (int i = 0; i < 2; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_f[i] = 0; h1[i] = 0; h2[i] = 0;
      end
    end else begin
      model_step();
    end
    #1;
    if (rst_n) begin
      check("rdata", int'(bus_rdata), exp_rd(int'(bus_addr)));
      check("flag0", int'(flag0), int'(m_f[0]));
      check("flag1", int'(flag1), int'(m_f[1]));
    end
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cyc(int n, bit rnd_gate, bit rnd_ack);
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        ev_i[i]  = 1'($urandom % 2);
        if (rnd_gate) gp_i[i] = 1'($urandom % 2);
        ack_i[i] = rnd_ack && ($urandom % 8 == 0);
      end
      bus_addr = 3'($urandom % 6);
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      run_i[i] = 0; gp_i[i] = 0; ev_i[i] = 0; ack_i[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values across all addresses
    cur_req = "R1";
    for (int a = 0; a < 6; a++) begin
      @(negedge clk); bus_addr = 3'(a);
    end

    // R2: register map and readback
    cur_req = "R2";
    wr(0, 8'hA5); wr(1, 8'h12); wr(2, 8'h34); wr(3, 8'h56); wr(4, 8'h78);
    cyc(8, 0, 0);

    // R6: 16-bit wrap
    cur_req = "R6";
    wr(0, 8'h01); wr(2, 8'hFF); wr(1, 8'hF0);
    run_i[0] = 1; cyc(40, 0, 1); run_i[0] = 0;

    // R5: 13-bit prescaled count, upper low-byte bits hold
    cur_req = "R5";
    wr(0, 8'h00); wr(2, 8'hFF); wr(1, 8'hFE);
    run_i[0] = 1; cyc(80, 0, 1); run_i[0] = 0;

    // R7: auto-reload
    cur_req = "R7";
    wr(0, 8'h02); wr(2, 8'hF0); wr(1, 8'hFA);
    run_i[0] = 1; cyc(70, 0, 1); run_i[0] = 0;

    // R4: channel 1 counts event pin falls
    cur_req = "R4";
    wr(0, 8'h50); wr(4, 8'hFF); wr(3, 8'hF8);
    run_i[1] = 1; cyc(300, 0, 1); run_i[1] = 0;

    // R3: gate qualification on channel 0 and channel 1
    cur_req = "R3";
    wr(0, 8'h99); wr(2, 8'hFF); wr(1, 8'h80);
    run_i[0] = 1; run_i[1] = 1; cyc(300, 1, 1);
    run_i[0] = 0; cyc(40, 1, 1); run_i[1] = 0;

    // R8: channel 1 stopped in its own mode 11
    cur_req = "R8";
    wr(0, 8'h30); wr(3, 8'hFE); run_i[1] = 1; cyc(50, 0, 1);

    // R9: split mode on channel 0, channel 1 frozen
    cur_req = "R9";
    wr(0, 8'h17); wr(1, 8'hF0); wr(2, 8'hF8); wr(3, 8'hFF); wr(4, 8'hFF);
    run_i[0] = 1; cyc(600, 1, 1);
    run_i[1] = 0; cyc(40, 1, 1);

    // R10: frequent acknowledges against frequent overflows
    cur_req = "R10";
    wr(0, 8'h22); wr(2, 8'hFE); wr(4, 8'hFC);
    run_i[0] = 1; run_i[1] = 1;
    repeat (400) begin
      @(negedge clk);
      ack_i[0] = 1'($urandom % 2); ack_i[1] = 1'($urandom % 2);
      bus_addr = 3'($urandom % 6);
    end
    ack_i[0] = 0; ack_i[1] = 0;

    // R11: writes colliding with counting, including control writes
    cur_req = "R11";
    repeat (3000) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        run_i[i] = 1'($urandom % 4 != 0);
        gp_i[i]  = 1'($urandom % 2);
        ev_i[i]  = 1'($urandom % 2);
        ack_i[i] = ($urandom % 6 == 0);
      end
      bus_wr    = ($urandom % 3 == 0);
      bus_addr  = 3'($urandom % 6);
      bus_wdata = 8'(($urandom % 4 == 0) ? 8'hFF - ($urandom % 3) : $urandom);
    end
    @(negedge clk); bus_wr = 1'b0;
    cyc(10, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule